// File: doc/BRIEF.md
# Pipelined Population Count Unit

This execution unit returns the number of set bits in an operand that is 16, 32 or 64 bits wide. The width is chosen separately for each operation with a two-bit size code. The operand is cut into 4-bit chunks. Every chunk goes through its own 16-entry constant table at the same moment, and each table gives that chunk's bit count. A narrow adder tree then adds those small counts. The adder only has to hold values up to 64, so it needs seven bits, which is far narrower than the operand.

A compile-time parameter chooses between two forms. One is purely combinational and returns the count in the cycle the operand is presented. The other is a three-stage registered pipeline. It registers the chunk counts first, then the group partial sums, then the final total. It accepts a new operand on every clock. A valid bit travels with each operation. The producer raises `in_valid` with the operand and size, and the consumer takes `out_count` whenever `out_valid` is high.

Top module: `popc_unit`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of ones among the operand bits inside the selected width. The bits are those of the operation that was issued with that result.
- R2: Size code 0 selects bits 15:0, code 1 selects bits 31:0, and codes 2 and 3 select bits 63:0. Operand bits above the selected width have no effect on the count.
- R3: `out_count` is 7 bits wide. An all-ones 64-bit operand gives 64, and no result ever exceeds 64.
- R4: With `PIPELINED=1`, an operation sampled with `in_valid` high at a rising edge shows `out_valid` high after the third rising edge from that one. A cycle without `in_valid` shows `out_valid` low three edges later.
- R5: With `PIPELINED=1`, operations issued on consecutive cycles each produce their own result, one per cycle, in issue order.
- R6: A rising edge with `rst_n` low clears every valid bit in the pipeline. `out_valid` is low from that edge until new operations reach the output, and operations that were in flight are dropped.
- R7: With `PIPELINED=0`, `out_valid` follows `in_valid` in the same cycle. `out_count` is the count of the operand presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid bits |
| in_valid | input | 1 | Operation present this cycle |
| in_operand | input | 64 | Operand whose set bits are counted |
| in_size | input | 2 | Width code: 0 = 16, 1 = 32, 2 or 3 = 64 bits |
| out_valid | output | 1 | Result present this cycle |
| out_count | output | 7 | Number of set bits in the selected width |

## Verification
In the pipelined form a result is due after the third rising edge from the edge that sampled its operand. The bench pushes each expected count into a three-deep model that it shifts on every edge. It compares the output a short delay after each edge against the oldest model entry. This way idle cycles, back-to-back issue and a reset in mid-stream are all checked in the exact cycle they are due. The combinational instance is due in the same cycle, so it is checked a short delay after the inputs change at the falling edge. Every expected value comes from a bit-by-bit count limited to the selected width.

// File: rtl/popc_pkg.sv
// Package: popc_pkg
// Shared types and constants for the population count unit.
// Assumes the operand is built from whole 4-bit chunks.
package popc_pkg;
    localparam int CHUNK_W = 4;
    localparam int CHUNK_CNT_W = 3;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64B = 2'd3
    } opsize_e;

    // Number of operand bits selected by a size code.
    function automatic int size_bits(input opsize_e sz);
        case (sz)
            SZ_16:   return 16;
            SZ_32:   return 32;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/popc_chunk_mask.sv
// Module: popc_chunk_mask
// Turns the per-operation size code into one enable bit per 4-bit chunk.
// Assumes the selected widths are multiples of the chunk width.
module popc_chunk_mask
    import popc_pkg::*;
#(
    parameter int NCHUNK = 16
) (
    input  logic [1:0]        size,
    output logic [NCHUNK-1:0] chunk_en
);
    // Enable every chunk that lies below the selected width.
    always_comb begin
        int lim;
        lim = size_bits(opsize_e'(size)) / CHUNK_W;
        for (int i = 0; i < NCHUNK; i++) begin
            chunk_en[i] = (i < lim);
        end
    end
endmodule

// File: rtl/popc_nibble_lut.sv
// Module: popc_nibble_lut
// A 16-entry constant table that maps one 4-bit chunk to its set-bit count (0..4).
// Assumes that a disabled chunk must contribute zero.
module popc_nibble_lut
    import popc_pkg::*;
(
    input  logic [CHUNK_W-1:0]     nib,
    input  logic                   en,
    output logic [CHUNK_CNT_W-1:0] cnt
);
    logic [CHUNK_CNT_W-1:0] tbl;

    // Table lookup for the chunk's bit count.
    always_comb begin
        case (nib)
            4'h0: tbl = 3'd0;
            4'h1: tbl = 3'd1;
            4'h2: tbl = 3'd1;
            4'h3: tbl = 3'd2;
            4'h4: tbl = 3'd1;
            4'h5: tbl = 3'd2;
            4'h6: tbl = 3'd2;
            4'h7: tbl = 3'd3;
            4'h8: tbl = 3'd1;
            4'h9: tbl = 3'd2;
            4'hA: tbl = 3'd2;
            4'hB: tbl = 3'd3;
            4'hC: tbl = 3'd2;
            4'hD: tbl = 3'd3;
            4'hE: tbl = 3'd3;
            default: tbl = 3'd4;
        endcase
    end

    // Force chunks outside the selected width to zero.
    assign cnt = en ? tbl : '0;
endmodule

// File: rtl/popc_group_sum.sv
// Module: popc_group_sum
// Adds GRP chunk counts into one narrow partial sum.
// Assumes each input count is at most 4.
module popc_group_sum
    import popc_pkg::*;
#(
    parameter int GRP = 4,
    localparam int GSW = $clog2(4 * GRP + 1)
) (
    input  logic [GRP-1:0][CHUNK_CNT_W-1:0] cnts,
    output logic [GSW-1:0]                  sum
);
    // Narrow addition of the group's chunk counts.
    always_comb begin
        sum = '0;
        for (int i = 0; i < GRP; i++) begin
            sum = sum + GSW'(cnts[i]);
        end
        p_grp_range_r1: assert (sum <= GSW'(4 * GRP))
            else $error("group partial sum out of range");
    end
endmodule

// File: rtl/popc_unit.sv
// Module: popc_unit
// Counts the set bits of a 16/32/64-bit operand. Parallel chunk tables feed a
// narrow adder tree. PIPELINED=1 registers three stages (chunk counts, group
// sums, total) at one operation per clock. PIPELINED=0 is combinational.
// Assumes OPW is a multiple of 4*GRP. The reset clears only the valid bits.
module popc_unit
    import popc_pkg::*;
#(
    parameter int OPW       = 64,
    parameter int GRP       = 4,
    parameter bit PIPELINED = 1'b1,
    localparam int NCHUNK   = OPW / CHUNK_W,
    localparam int NGRP     = NCHUNK / GRP,
    localparam int GSW      = $clog2(4 * GRP + 1),
    localparam int CNT_W    = $clog2(OPW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   in_operand,
    input  logic [1:0]       in_size,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_count
);
    logic [NCHUNK-1:0]                   chunk_en;
    logic [NCHUNK-1:0][CHUNK_CNT_W-1:0]  chunk_cnt;

    popc_chunk_mask #(.NCHUNK(NCHUNK)) u_mask (
        .size     (in_size),
        .chunk_en (chunk_en)
    );

    // One table per chunk, all looked up in parallel.
    for (genvar c = 0; c < NCHUNK; c++) begin : g_lut
        popc_nibble_lut u_lut (
            .nib (in_operand[c*CHUNK_W +: CHUNK_W]),
            .en  (chunk_en[c]),
            .cnt (chunk_cnt[c])
        );
    end

    if (PIPELINED) begin : g_pipe
        logic                                s1_v, s2_v, s3_v;
        logic [NCHUNK-1:0][CHUNK_CNT_W-1:0]  s1_cnt;
        logic [NGRP-1:0][GSW-1:0]            grp_sum, s2_grp;
        logic [CNT_W-1:0]                    total, s3_cnt;
        logic [1:0]                          since_rst;
        logic                                s1_upper_nz;

        // Stage valid chain; only these bits are reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_v <= 1'b0;
                s2_v <= 1'b0;
                s3_v <= 1'b0;
            end else begin
                s1_v <= in_valid;
                s2_v <= s1_v;
                s3_v <= s2_v;
            end
        end

        // Stage 1: register the chunk counts.
        always_ff @(posedge clk) s1_cnt <= chunk_cnt;

        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            popc_group_sum #(.GRP(GRP)) u_gsum (
                .cnts (s1_cnt[g*GRP +: GRP]),
                .sum  (grp_sum[g])
            );
        end

        // Stage 2: register the group partial sums.
        always_ff @(posedge clk) s2_grp <= grp_sum;

        // Final narrow addition of the group sums.
        always_comb begin
            total = '0;
            for (int g = 0; g < NGRP; g++) total = total + CNT_W'(s2_grp[g]);
        end

        // Stage 3: register the final count.
        always_ff @(posedge clk) s3_cnt <= total;

        assign out_valid = s3_v;
        assign out_count = s3_cnt;

        // Cycles since reset release, saturating at 3, for the latency check.
        always_ff @(posedge clk) begin
            if (!rst_n)               since_rst <= 2'd0;
            else if (since_rst != 3) since_rst <= since_rst + 2'd1;
        end

        // Whether any stage-1 chunk above the 16-bit width is non-zero.
        always_comb begin
            s1_upper_nz = 1'b0;
            for (int c = 16 / CHUNK_W; c < NCHUNK; c++) s1_upper_nz |= (s1_cnt[c] != '0);
        end

        p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));
        p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_size == SZ_16) |=> !s1_upper_nz);
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_count <= CNT_W'(OPW)));
    end else begin : g_comb
        logic [NGRP-1:0][GSW-1:0] grp_sum;
        logic [CNT_W-1:0]         total;

        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            popc_group_sum #(.GRP(GRP)) u_gsum (
                .cnts (chunk_cnt[g*GRP +: GRP]),
                .sum  (grp_sum[g])
            );
        end

        // Same-cycle total of the group sums.
        always_comb begin
            total = '0;
            for (int g = 0; g < NGRP; g++) total = total + CNT_W'(grp_sum[g]);
        end

        assign out_valid = in_valid;
        assign out_count = total;

        p_comb_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_count <= CNT_W'(OPW)));
    end
endmodule

// File: tb/popc_unit_tb.sv
// Directed bench for popc_unit: pipelined instance u_dut, combinational u_comb.
module popc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_size = '0;
    logic        out_valid, c_valid;
    logic [6:0]  out_count, c_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected model of the three pipeline stages.
    bit       ev[3];
    int       ec[3];
    string    et[3];
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    popc_unit #(.OPW(64), .GRP(4), .PIPELINED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_size(in_size), .out_valid(out_valid), .out_count(out_count));

    popc_unit #(.OPW(64), .GRP(4), .PIPELINED(1'b0)) u_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_size(in_size), .out_valid(c_valid), .out_count(c_count));

    function automatic int ref_count(input logic [63:0] op, input logic [1:0] sz);
        int n = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        int k = 0;
        for (int i = 0; i < n; i++) k += int'(op[i]);
        return k;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ec[i] = 0; et[i] = "R6"; end
    endtask

    // One clock: drive at the falling edge, check both instances where due.
    task automatic cycle(input bit v, input logic [63:0] op, input logic [1:0] sz,
                         input string tag);
        @(negedge clk);
        in_valid = v; in_operand = op; in_size = sz;
        #1;
        chk(c_valid == v, "R7", "comb valid", int'(c_valid), int'(v));
        if (v) chk(int'(c_count) == ref_count(op, sz), "R7", {tag, " comb count"},
                   int'(c_count), ref_count(op, sz));
        @(posedge clk);
        ev[2] = ev[1]; ec[2] = ec[1]; et[2] = et[1];
        ev[1] = ev[0]; ec[1] = ec[0]; et[1] = et[0];
        ev[0] = v; ec[0] = ref_count(op, sz); et[0] = tag;
        #1;
        chk(out_valid == ev[2], "R4", {et[2], " pipe valid"}, int'(out_valid), int'(ev[2]));
        if (ev[2]) chk(int'(out_count) == ec[2], et[2], "pipe count",
                       int'(out_count), ec[2]);
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) cycle(1'b0, '0, 2'd2, "R4");
    endtask

    function automatic logic [63:0] next_rand();
        rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
        return rng;
    endfunction

    // R6: out_valid low while and after reset is applied.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk(out_valid == 1'b0, "R6", "valid in reset", int'(out_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        clear_model();
    endtask

    // R1/R2: all-zero operands at each size.
    task automatic t_zeros();
        for (int s = 0; s < 4; s++) cycle(1'b1, '0, 2'(s), "R1");
        drain();
    endtask

    // R2/R3: all-ones at each size gives 16, 32, 64, 64 (upper bits ignored).
    task automatic t_ones();
        for (int s = 0; s < 4; s++) cycle(1'b1, '1, 2'(s), "R3");
        drain();
    endtask

    // R2: a single set bit walked across all positions at every size, back to back.
    task automatic t_single();
        for (int s = 0; s < 3; s++)
            for (int b = 0; b < 64; b++) cycle(1'b1, 64'd1 << b, 2'(s), "R2");
        drain();
    endtask

    // R1/R5: random operands, back to back, every size.
    task automatic t_random();
        for (int i = 0; i < 200; i++) cycle(1'b1, next_rand(), 2'(i % 4), "R5");
        drain();
    endtask

    // R4: issue with bubbles between operations.
    task automatic t_bubbles();
        for (int i = 0; i < 40; i++) cycle((i % 3) != 1, next_rand(), 2'(i % 3), "R4");
        drain();
    endtask

    // R6: reset in mid-stream drops in-flight operations.
    task automatic t_mid_reset();
        for (int i = 0; i < 3; i++) cycle(1'b1, next_rand(), 2'd2, "R6");
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1 chk(out_valid == 1'b0, "R6", "valid after mid reset", int'(out_valid), 0);
        @(posedge clk);
        #1 chk(out_valid == 1'b0, "R6", "valid held in reset", int'(out_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        clear_model();
        drain();
    endtask

    initial begin
        t_reset();
        t_zeros();
        t_ones();
        t_single();
        t_random();
        t_bubbles();
        t_mid_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule